// File: doc/BRIEF.md
# Strobe Delay-Setting Tracker

This block is the digital half of a delay-locked loop that sets the input delay of strobe pins for source-synchronous memory capture. A phase comparator, outside this block, reports whether the delay line is short or long against the reference clock. The block turns those reports into a binary delay count. It moves the count at a slow, mode-dependent rate, so that it follows drift in process, voltage and temperature and ignores comparator dither.

Two delay settings come from that single count. Each one adds its own signed offset to the count, clamps the sum to the code range and converts it to Gray code, so that a tracking step flips only one wire in the delay chain. Each setting is copied unchanged to every consumer group, for example the strobe groups on several sides of the die. A lock flag stays low until the lock interval has run. The interval is longer in the low-jitter mode. While the flag is low, data capture must be held off because the settings may still be moving.

Top module: `dqs_delay_tracker`

## Requirements
- R1: Each setting output carries the Gray code of its binary value, g = b xor (b >> 1), on 7 bits.
- R2: With `low_jitter_mode` low, `locked` rises on the 256th rising edge after the edge at which `rst` was last sampled high.
- R3: With `low_jitter_mode` high, `locked` rises on the 1280th rising edge after the edge at which `rst` was last sampled high.
- R4: `locked` is low for the whole lock interval. Once high, it stays high until a reset or a mode change.
- R5: A change of `low_jitter_mode`, sampled at a rising edge, drops `locked` at that edge. The lock interval of the new mode then restarts from that edge. The delay count keeps its value.
- R6: The delay count can change only on every 8th edge in normal mode and on every 32nd edge in low-jitter mode, counted from the reset or mode-change edge. A setting output shows a new count one edge after the count changes.
- R7: At an update edge, `pd_up` alone adds one to the count and `pd_dn` alone subtracts one. When both or neither are high, the count holds. The count saturates at 0 and at 127.
- R8: Setting A is the Gray code of clamp(count + `ofs_a`, 0, 127) and setting B is the same with `ofs_b`. Both offsets are 8-bit two's complement. An offset change appears at the output one edge later.
- R9: Each bus holds 3 identical copies of its setting. Copy i occupies bits [7*i+6 : 7*i].
- R10: A synchronous reset sets the count to 64, drives `locked` low and sets both settings to Gray(64) = 7'h60.
- R11: While the offsets are steady, no setting output changes more than one bit from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| low_jitter_mode | input | 1 | 1 selects the low-jitter mode (longer lock and update intervals) |
| pd_up | input | 1 | Phase comparator: lengthen the delay |
| pd_dn | input | 1 | Phase comparator: shorten the delay |
| ofs_a | input | 8 | Signed offset for setting A |
| ofs_b | input | 8 | Signed offset for setting B |
| set_a_bus | output | 21 | Setting A in Gray code, one 7-bit copy per consumer group |
| set_b_bus | output | 21 | Setting B in Gray code, one 7-bit copy per consumer group |
| locked | output | 1 | Lock flag and capture enable |

## Verification
Edges are counted from the last edge at which reset (or a mode change) was sampled. `locked` is due exactly on edge 256 or 1280, so the checks sample one edge before and on that edge. A count step taken on update edge N reaches the setting outputs on edge N+1, and an offset change reaches them one edge after it is driven. The checks sample on edge N and on edge N+1 to pin that latency. All inputs are driven and all outputs sampled 1 ns after a rising edge, so no result depends on the order of processes at the edge.

// File: rtl/dqs_dly_pkg.sv
package dqs_dly_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_LOWJIT = 1'b1
    } dll_mode_e;

    // Clamp an integer into [0, hi]
    function automatic int clamp_range(input int v, input int hi);
        if (v < 0) return 0;
        if (v > hi) return hi;
        return v;
    endfunction

    // Binary to reflected Gray code
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction
endpackage

// File: rtl/dll_lock_timer.sv
module dll_lock_timer
    import dqs_dly_pkg::*;
#(
    parameter int unsigned NORM_LOCK = 256,
    parameter int unsigned LOWJ_LOCK = 1280
) (
    input  logic      clk,
    input  logic      rst,
    input  dll_mode_e mode_i,
    output dll_mode_e mode_q_o,
    output logic      mode_chg_o,
    output logic      locked_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned MAX_LOCK = (LOWJ_LOCK > NORM_LOCK) ? LOWJ_LOCK : NORM_LOCK;
    localparam int unsigned CNT_W    = $clog2(MAX_LOCK + 1);
    localparam logic [CNT_W-1:0] NORM_LAST = CNT_W'(NORM_LOCK - 1);
    localparam logic [CNT_W-1:0] LOWJ_LAST = CNT_W'(LOWJ_LOCK - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             locked;
        dll_mode_e        mode;
    } lock_st_t;

    lock_st_t         st_d, st_q;
    logic [CNT_W-1:0] last_w;

    always_comb begin
        mode_chg_o = (mode_i != st_q.mode);
        last_w     = (st_q.mode == MODE_LOWJIT) ? LOWJ_LAST : NORM_LAST;
        st_d       = st_q;
        if (rst || mode_chg_o) begin
            // R10 / R5: restart the lock interval
            st_d.cnt    = '0;
            st_d.locked = 1'b0;
            st_d.mode   = mode_i;
        end else if (!st_q.locked) begin
            st_d.cnt    = st_q.cnt + 1'b1;
            st_d.locked = (st_q.cnt == last_w);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mode_q_o = st_q.mode;
    assign locked_o = st_q.locked;

    logic armed_q;
    always_ff @(posedge clk) begin
        armed_q <= !rst;
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        (st_q.locked && !mode_chg_o) |=> st_q.locked); // R4
    AST_LOCK_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (armed_q && $rose(st_q.locked)) |-> ($past(st_q.cnt) == $past(last_w))); // R2 R3
    AST_NO_EARLY_LOCK: assert property (@(posedge clk) disable iff (rst)
        st_q.locked |-> (st_q.cnt == last_w + 1'b1)); // R4
    AST_RESTART_DROPS: assert property (@(posedge clk) disable iff (rst)
        mode_chg_o |=> (!st_q.locked && (st_q.mode == $past(mode_i)))); // R5
endmodule

// File: rtl/dll_step_counter.sv
module dll_step_counter
    import dqs_dly_pkg::*;
#(
    parameter int unsigned CODE_W   = 7,
    parameter int unsigned NORM_UPD = 8,
    parameter int unsigned LOWJ_UPD = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart_i,
    input  dll_mode_e         mode_i,
    input  logic              pd_up,
    input  logic              pd_dn,
    output logic [CODE_W-1:0] code_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned MAX_UPD = (LOWJ_UPD > NORM_UPD) ? LOWJ_UPD : NORM_UPD;
    localparam int unsigned UPD_W   = $clog2(MAX_UPD + 1);
    localparam logic [UPD_W-1:0]  NORM_LAST = UPD_W'(NORM_UPD - 1);
    localparam logic [UPD_W-1:0]  LOWJ_LAST = UPD_W'(LOWJ_UPD - 1);
    localparam logic [CODE_W-1:0] CODE_MID  = {1'b1, {(CODE_W-1){1'b0}}};
    localparam logic [CODE_W-1:0] CODE_TOP  = '1;

    typedef struct packed {
        logic [UPD_W-1:0]  upd;
        logic [CODE_W-1:0] code;
    } step_st_t;

    step_st_t         st_d, st_q;
    logic [UPD_W-1:0] last_w;
    logic             tick_w;

    always_comb begin
        last_w = (mode_i == MODE_LOWJIT) ? LOWJ_LAST : NORM_LAST;
        tick_w = (st_q.upd == last_w);
        st_d   = st_q;
        if (rst) begin
            st_d.upd  = '0;
            st_d.code = CODE_MID;           // R10
        end else if (restart_i) begin
            st_d.upd  = '0;                 // R5: count kept, cadence restarts
        end else if (tick_w) begin
            st_d.upd = '0;
            if (pd_up && !pd_dn && (st_q.code != CODE_TOP)) begin
                st_d.code = st_q.code + 1'b1;
            end else if (pd_dn && !pd_up && (st_q.code != '0)) begin
                st_d.code = st_q.code - 1'b1;
            end
        end else begin
            st_d.upd = st_q.upd + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign code_o = st_q.code;

    logic armed_q;
    always_ff @(posedge clk) begin
        armed_q <= !rst;
    end

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> ((st_q.code == $past(st_q.code)) ||
                     (st_q.code == $past(st_q.code) + 1'b1) ||
                     (st_q.code == $past(st_q.code) - 1'b1))); // R7
    AST_MOVE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (armed_q && (st_q.code != $past(st_q.code))) |-> ($past(tick_w) && !$past(restart_i))); // R6
    AST_CEILING_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (armed_q && $past(st_q.code == CODE_TOP) && $past(pd_up)) |-> (st_q.code == CODE_TOP)); // R7
    AST_FLOOR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (armed_q && $past(st_q.code == '0) && $past(pd_dn)) |-> (st_q.code == '0)); // R7
endmodule

// File: rtl/dll_offset_stage.sv
module dll_offset_stage
    import dqs_dly_pkg::*;
#(
    parameter int unsigned CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_i,
    input  logic [CODE_W:0]   ofs_i,
    output logic [CODE_W-1:0] gray_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CODE_MAX = (1 << CODE_W) - 1;
    localparam logic [CODE_W-1:0] RST_GRAY = CODE_W'(to_gray(32'(1 << (CODE_W - 1))));

    typedef struct packed {
        logic [CODE_W-1:0] gray;
    } ofs_st_t;

    ofs_st_t           st_d, st_q;
    int                sum_w;
    logic [CODE_W-1:0] bin_w;

    always_comb begin
        // R8: signed offset, clamped, then Gray (R1)
        sum_w = int'(code_i) + int'($signed(ofs_i));
        bin_w = CODE_W'(clamp_range(sum_w, CODE_MAX));
        st_d  = st_q;
        if (rst) begin
            st_d.gray = RST_GRAY;
        end else begin
            st_d.gray = CODE_W'(to_gray(32'(bin_w)));
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign gray_o = st_q.gray;

    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            warm_q <= '0;
        end else if (warm_q != 2'd3) begin
            warm_q <= warm_q + 1'b1;
        end
    end

    AST_GRAY_SINGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
        ((warm_q >= 2'd2) && ($past(ofs_i) == $past(ofs_i, 2)))
            |-> ($countones(st_q.gray ^ $past(st_q.gray)) <= 1)); // R11
    AST_STEADY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        ((warm_q >= 2'd2) && $past(code_i == $past(code_i)) && ($past(ofs_i) == $past(ofs_i, 2)))
            |-> $stable(st_q.gray)); // R8
endmodule

// File: rtl/dqs_delay_tracker.sv
module dqs_delay_tracker
    import dqs_dly_pkg::*;
#(
    parameter int unsigned CODE_W    = 7,
    parameter int unsigned N_SIDES   = 3,
    parameter int unsigned NORM_LOCK = 256,
    parameter int unsigned LOWJ_LOCK = 1280,
    parameter int unsigned NORM_UPD  = 8,
    parameter int unsigned LOWJ_UPD  = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      low_jitter_mode,
    input  logic                      pd_up,
    input  logic                      pd_dn,
    input  logic [CODE_W:0]           ofs_a,
    input  logic [CODE_W:0]           ofs_b,
    output logic [N_SIDES*CODE_W-1:0] set_a_bus,
    output logic [N_SIDES*CODE_W-1:0] set_b_bus,
    output logic                      locked
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned N_TAPS = 2;

    dll_mode_e         mode_in_w;
    dll_mode_e         mode_q_w;
    logic              mode_chg_w;
    logic [CODE_W-1:0] code_w;
    logic [CODE_W:0]   ofs_arr  [N_TAPS];
    logic [CODE_W-1:0] tap_gray [N_TAPS];

    assign mode_in_w  = dll_mode_e'(low_jitter_mode);
    assign ofs_arr[0] = ofs_a;
    assign ofs_arr[1] = ofs_b;

    dll_lock_timer #(
        .NORM_LOCK (NORM_LOCK),
        .LOWJ_LOCK (LOWJ_LOCK)
    ) u_lock (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode_in_w),
        .mode_q_o   (mode_q_w),
        .mode_chg_o (mode_chg_w),
        .locked_o   (locked)
    );

    dll_step_counter #(
        .CODE_W   (CODE_W),
        .NORM_UPD (NORM_UPD),
        .LOWJ_UPD (LOWJ_UPD)
    ) u_step (
        .clk       (clk),
        .rst       (rst),
        .restart_i (mode_chg_w),
        .mode_i    (mode_q_w),
        .pd_up     (pd_up),
        .pd_dn     (pd_dn),
        .code_o    (code_w)
    );

    for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
        dll_offset_stage #(
            .CODE_W (CODE_W)
        ) u_ofs (
            .clk    (clk),
            .rst    (rst),
            .code_i (code_w),
            .ofs_i  (ofs_arr[t]),
            .gray_o (tap_gray[t])
        );
    end

    // R9: identical copy per consumer group
    for (genvar s = 0; s < N_SIDES; s++) begin : g_side
        assign set_a_bus[s*CODE_W +: CODE_W] = tap_gray[0];
        assign set_b_bus[s*CODE_W +: CODE_W] = tap_gray[1];
    end
endmodule

// File: tb/dqs_delay_tracker_bench.sv
module dqs_delay_tracker_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CW = 7;
    localparam int NS = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           low_jitter_mode = 1'b0;
    logic           pd_up = 1'b0;
    logic           pd_dn = 1'b0;
    logic [CW:0]    ofs_a = '0;
    logic [CW:0]    ofs_b = '0;
    logic [NS*CW-1:0] set_a_bus;
    logic [NS*CW-1:0] set_b_bus;
    logic           locked;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    dqs_delay_tracker u_dqs_delay_tracker (
        .clk             (clk),
        .rst             (rst),
        .low_jitter_mode (low_jitter_mode),
        .pd_up           (pd_up),
        .pd_dn           (pd_dn),
        .ofs_a           (ofs_a),
        .ofs_b           (ofs_b),
        .set_a_bus       (set_a_bus),
        .set_b_bus       (set_b_bus),
        .locked          (locked)
    );

    function automatic int g7(input int b);
        return (b ^ (b >> 1)) & 127;
    endfunction

    task automatic adv(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic lj, input logic up, input logic dn);
        @(posedge clk);
        #1;
        rst = 1'b1;
        low_jitter_mode = lj;
        pd_up = up;
        pd_dn = dn;
        ofs_a = '0;
        ofs_b = '0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Binary expectations; compares every copy in both buses (R9)
    task automatic chk_out(input int ea, input int eb, input string tag);
        bit ok = 1'b1;
        checks++;
        for (int s = 0; s < NS; s++) begin
            if (int'(set_a_bus[s*CW +: CW]) != g7(ea)) ok = 1'b0;
            if (int'(set_b_bus[s*CW +: CW]) != g7(eb)) ok = 1'b0;
        end
        if (!ok) begin
            failures++;
            $display("FAIL %s R9: actual a=%h b=%h expected copies of a=%h b=%h",
                     tag, set_a_bus, set_b_bus, g7(ea), g7(eb));
        end
    endtask

    task automatic t_reset();
        do_reset(1'b0, 1'b0, 1'b0);
        chk(int'(locked), 0, "R10 locked low after reset");
        chk_out(64, 64, "R10 R1 reset settings gray(64)");
    endtask

    task automatic t_lock_normal();
        int early = 0;
        do_reset(1'b0, 1'b0, 1'b0);
        for (int k = 1; k <= 255; k++) begin
            adv(1);
            if (locked) early++;
        end
        chk(early, 0, "R4 locked low through normal interval");
        chk(int'(locked), 0, "R2 locked low at edge 255");
        adv(1);
        chk(int'(locked), 1, "R2 locked high at edge 256");
        adv(500);
        chk(int'(locked), 1, "R4 locked stays high");
    endtask

    task automatic t_lock_lowjit();
        do_reset(1'b1, 1'b0, 1'b0);
        adv(1279);
        chk(int'(locked), 0, "R3 locked low at edge 1279");
        adv(1);
        chk(int'(locked), 1, "R3 locked high at edge 1280");
    endtask

    task automatic t_track_normal();
        do_reset(1'b0, 1'b1, 1'b0);
        adv(8);
        chk_out(64, 64, "R6 no output change at edge 8");
        adv(1);
        chk_out(65, 65, "R6 R7 up step visible at edge 9");
        adv(7);
        chk_out(65, 65, "R6 held between updates");
        adv(1);
        chk_out(66, 66, "R6 second step at edge 17");
        pd_up = 1'b0;
        pd_dn = 1'b1;
        adv(8);
        chk_out(65, 65, "R7 down step");
        pd_up = 1'b1;
        adv(16);
        chk_out(65, 65, "R7 both asserted holds");
        pd_up = 1'b0;
        pd_dn = 1'b0;
        adv(16);
        chk_out(65, 65, "R7 neither asserted holds");
    endtask

    task automatic t_track_lowjit();
        do_reset(1'b1, 1'b1, 1'b0);
        adv(32);
        chk_out(64, 64, "R6 low-jitter no change at edge 32");
        adv(1);
        chk_out(65, 65, "R6 low-jitter step at edge 33");
    endtask

    task automatic t_saturate();
        int multi = 0;
        logic [CW-1:0] prev;
        do_reset(1'b0, 1'b1, 1'b0);
        adv(1);
        prev = set_a_bus[CW-1:0];
        for (int k = 0; k < 560; k++) begin
            adv(1);
            if ($countones(prev ^ set_a_bus[CW-1:0]) > 1) multi++;
            prev = set_a_bus[CW-1:0];
        end
        chk_out(127, 127, "R7 saturates at 127");
        pd_up = 1'b0;
        pd_dn = 1'b1;
        for (int k = 0; k < 1120; k++) begin
            adv(1);
            if ($countones(prev ^ set_a_bus[CW-1:0]) > 1) multi++;
            prev = set_a_bus[CW-1:0];
        end
        chk_out(0, 0, "R7 saturates at 0");
        chk(multi, 0, "R11 multi-bit flips during tracking");
    endtask

    task automatic t_offsets();
        do_reset(1'b0, 1'b0, 1'b0);
        ofs_a = 8'd10;
        ofs_b = 8'hFB;      // -5
        adv(1);
        chk_out(74, 59, "R8 offsets +10 and -5");
        ofs_a = 8'd100;
        ofs_b = 8'h9C;      // -100
        #1;
        chk_out(74, 59, "R8 offset not seen before edge");
        adv(1);
        chk_out(127, 0, "R8 offsets clamp high and low");
        ofs_a = 8'h80;      // -128
        ofs_b = 8'h7F;      // +127
        adv(1);
        chk_out(0, 127, "R8 extreme offsets clamp");
    endtask

    task automatic t_mode_change();
        do_reset(1'b0, 1'b1, 1'b0);
        adv(20);
        pd_up = 1'b0;
        adv(236);
        chk(int'(locked), 1, "R2 locked before mode change");
        chk_out(66, 66, "R5 count before mode change");
        low_jitter_mode = 1'b1;
        adv(1);
        chk(int'(locked), 0, "R5 mode change drops lock");
        chk_out(66, 66, "R5 count kept across mode change");
        adv(1279);
        chk(int'(locked), 0, "R5 R3 low at 1279 after change");
        adv(1);
        chk(int'(locked), 1, "R5 R3 relock at 1280 after change");
        low_jitter_mode = 1'b0;
        adv(1);
        chk(int'(locked), 0, "R5 change back drops lock");
        adv(255);
        chk(int'(locked), 0, "R5 R2 low at 255 after change");
        adv(1);
        chk(int'(locked), 1, "R5 R2 relock at 256 after change");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_lock_normal();
        t_lock_lowjit();
        t_track_normal();
        t_track_lowjit();
        t_saturate();
        t_offsets();
        t_mode_change();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule